// File: doc/BRIEF.md
# Pulse-Stepped Three-Line Sequence Flag

This block watches three event lines, each of which carries one-cycle pulses, and raises a level flag once the lines have pulsed in the order A, then B, then C while the flag is low. After that the flag holds high, whatever happens on A or C, until the next B pulse clears it. The state moves only on cycles where a pulse arrives. Between pulses the flag and the state hold, so the flag can be read at any time as a plain level.

The machine has four states. It stores them in two set/clear storage bits, which set and clear excitation logic drives. The state codes follow a reflected binary order: idle 00, A-seen 01, A-B-seen 11, flag-held 10. The flag comes straight from the stored state (Moore style). It never depends on the pulse present in the current cycle. The event lines are assumed to be clean and synchronous one-cycle pulses. At most one line is meant to pulse in a given cycle. A cycle with more than one line high counts as malformed and is dropped.

Top module: `pulse_seq_detector`

## Requirements
- R1: A synchronous active-high reset puts the machine in the idle state (code 00), so `flag_out` is 0 in the cycle after the reset edge.
- R2: From idle, the pulses A, B, C on consecutive pulse events raise `flag_out` to 1 at the clock edge that samples the C pulse.
- R3: In a cycle with no line high, neither the state nor `flag_out` changes.
- R4: While the flag is low, an A pulse always moves the machine to the A-seen state, from idle, A-seen or A-B-seen. So A,A,B,C and A,B,A,B,C both raise the flag.
- R5: While the flag is low, a B pulse outside the A-seen state and a C pulse outside the A-B-seen state return the machine to idle. So A,C,B,C and A,B,B,C leave the flag at 0.
- R6: While the flag is high, A and C pulses leave it high.
- R7: While the flag is high, a B pulse clears it to 0 at the edge that samples that pulse, and the machine returns to idle.
- R8: A cycle in which two or more lines are high changes neither the state nor `flag_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_a | input | 1 | First event line, one-cycle pulses |
| line_b | input | 1 | Second event line, one-cycle pulses |
| line_c | input | 1 | Third event line, one-cycle pulses |
| flag_out | output | 1 | Held level, high in the flag-held state |

## Verification
The block has no tunable values: the number of lines and the two-bit state width are fixed by its function. The bench therefore builds it as it stands. With that one build it reaches all four state codes and every kind of pulse from each of them, including the two-bit jump from A-B-seen back to idle. It also covers restarts through A, quiet cycles in the middle of a sequence, malformed multi-line cycles both below and in the held state, and a reset applied while the flag is high.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    localparam int LINES = 3;
    localparam int STW   = 2;

    typedef enum logic [STW-1:0] {
        ST_IDLE = 2'b00,
        ST_A    = 2'b01,
        ST_AB   = 2'b11,
        ST_HELD = 2'b10
    } pseq_state_e;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } pulse_s;

    typedef struct packed {
        logic [STW-1:0] set;
        logic [STW-1:0] clr;
    } excite_s;

    // Next state for exactly one pulse present.
    function automatic pseq_state_e step(pseq_state_e cur, pulse_s p);
        pseq_state_e nxt;
        if (cur == ST_HELD) begin
            nxt = p.b ? ST_IDLE : ST_HELD;
        end else if (p.a) begin
            nxt = ST_A;
        end else if (p.b && cur == ST_A) begin
            nxt = ST_AB;
        end else if (p.c && cur == ST_AB) begin
            nxt = ST_HELD;
        end else begin
            nxt = ST_IDLE;
        end
        return nxt;
    endfunction

    // Set where a bit must rise, clear where it must fall.
    function automatic excite_s excite(logic [STW-1:0] cur, logic [STW-1:0] nxt);
        excite_s e;
        e.set = nxt & ~cur;
        e.clr = ~nxt & cur;
        return e;
    endfunction

endpackage

// File: rtl/pseq_pulse_decode.sv
module pseq_pulse_decode
    import pseq_pkg::*;
(
    input  logic   line_a,
    input  logic   line_b,
    input  logic   line_c,
    output pulse_s pulse,
    output logic   single,
    output logic   multi
);
    logic [LINES-1:0] lines;

    always_comb begin
        lines   = {line_a, line_b, line_c};
        pulse.a = line_a;
        pulse.b = line_b;
        pulse.c = line_c;
        single  = ($countones(lines) == 1);
        multi   = ($countones(lines) > 1);
    end
endmodule

// File: rtl/pseq_excite.sv
module pseq_excite
    import pseq_pkg::*;
(
    input  logic [STW-1:0] cur_bits,
    input  pulse_s         pulse,
    input  logic           single,
    output excite_s        drive
);
    pseq_state_e cur;
    pseq_state_e nxt;

    always_comb begin
        cur   = pseq_state_e'(cur_bits);
        nxt   = single ? step(cur, pulse) : cur;
        drive = excite(cur_bits, nxt);
    end
endmodule

// File: rtl/pseq_sr_bit.sv
module pseq_sr_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic s,
    input  logic r,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)    q <= RST_VAL;
        else if (s) q <= 1'b1;
        else if (r) q <= 1'b0;
    end

    // A set request is honoured on the next edge (supports R2, R4).
    assert_set_lands_R2: assert property (@(posedge clk) disable iff (rst)
        s |=> q);
endmodule

// File: rtl/pulse_seq_detector.sv
module pulse_seq_detector
    import pseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic line_a,
    input  logic line_b,
    input  logic line_c,
    output logic flag_out
);
    localparam logic [STW-1:0] RST_CODE = ST_IDLE;

    pulse_s          pulse;
    logic            single;
    logic            multi;
    excite_s         drive;
    logic [STW-1:0]  state_bits;
    pseq_state_e     state;

    pseq_pulse_decode u_decode (
        .line_a (line_a),
        .line_b (line_b),
        .line_c (line_c),
        .pulse  (pulse),
        .single (single),
        .multi  (multi)
    );

    pseq_excite u_excite (
        .cur_bits (state_bits),
        .pulse    (pulse),
        .single   (single),
        .drive    (drive)
    );

    for (genvar i = 0; i < STW; i++) begin : g_bit
        pseq_sr_bit #(.RST_VAL(RST_CODE[i])) u_bit (
            .clk (clk),
            .rst (rst),
            .s   (drive.set[i]),
            .r   (drive.clr[i]),
            .q   (state_bits[i])
        );
    end

    always_comb begin
        state    = pseq_state_e'(state_bits);
        flag_out = (state == ST_HELD);
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (state == ST_IDLE && !flag_out));

    assert_rise_on_c_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_out) |-> ($past(line_c) && $past(state) == ST_AB));

    assert_quiet_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!line_a && !line_b && !line_c) |=> $stable(state_bits));

    assert_fall_on_b_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_out && line_b && !line_a && !line_c) |=> (state == ST_IDLE));

    assert_multi_dropped_R8: assert property (@(posedge clk) disable iff (rst)
        multi |=> $stable(state_bits));
endmodule

// File: tb/pulse_seq_detector_tb_top.sv
module pulse_seq_detector_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_a = 1'b0;
    logic line_b = 1'b0;
    logic line_c = 1'b0;
    logic flag_out;

    int checks = 0;
    int errors = 0;

    bit    exp_q[$];
    string tag_q[$];

    pulse_seq_detector dut_i (
        .clk      (clk),
        .rst      (rst),
        .line_a   (line_a),
        .line_b   (line_b),
        .line_c   (line_c),
        .flag_out (flag_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: one expected item per edge, compared just after it.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (flag_out !== e) begin
                errors++;
                $display("FAIL %s: flag_out=%0b expected=%0b", t, flag_out, e);
            end
        end
    end

    // Driver: mask bit2=A, bit1=B, bit0=C; pushes the flag expected after the edge.
    task automatic drive(input logic [2:0] mask, input bit expz, input string tag);
        @(negedge clk);
        line_a = mask[2];
        line_b = mask[1];
        line_c = mask[0];
        exp_q.push_back(expz);
        tag_q.push_back(tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        line_a = 1'b0; line_b = 1'b0; line_c = 1'b0;
        exp_q.push_back(1'b0);
        tag_q.push_back(tag);
        @(negedge clk);
        rst = 1'b0;
    endtask

    localparam logic [2:0] NONE = 3'b000;
    localparam logic [2:0] PA = 3'b100;
    localparam logic [2:0] PB = 3'b010;
    localparam logic [2:0] PC = 3'b001;

    initial begin
        do_reset("R1 reset");
        // R2 basic sequence
        drive(PA, 0, "R2 A");
        drive(PB, 0, "R2 B");
        drive(PC, 1, "R2 C raises");
        // R6 A and C while held
        drive(PA, 1, "R6 A held");
        drive(PC, 1, "R6 C held");
        drive(NONE, 1, "R3 quiet held");
        // R7 clear
        drive(PB, 0, "R7 B clears");
        // R5 wrong pulses
        drive(PB, 0, "R5 B from idle");
        drive(PA, 0, "R5 A");
        drive(PC, 0, "R5 C wrong");
        drive(PB, 0, "R5 B wrong");
        drive(PC, 0, "R5 C no flag");
        drive(PA, 0, "R5 A");
        drive(PB, 0, "R5 B");
        drive(PB, 0, "R5 B twice");
        drive(PC, 0, "R5 C after BB");
        // R4 restarts
        drive(PA, 0, "R4 A");
        drive(PA, 0, "R4 A again");
        drive(PB, 0, "R4 B");
        drive(PC, 1, "R4 AABC raises");
        drive(PB, 0, "R7 B clears");
        drive(PA, 0, "R4 A");
        drive(PB, 0, "R4 B");
        drive(PA, 0, "R4 A restart");
        drive(PB, 0, "R4 B");
        drive(PC, 1, "R4 ABABC raises");
        drive(PB, 0, "R7 B clears");
        // R3 quiet gaps
        drive(PA, 0, "R3 A");
        drive(NONE, 0, "R3 gap");
        drive(NONE, 0, "R3 gap");
        drive(PB, 0, "R3 B");
        drive(NONE, 0, "R3 gap");
        drive(PC, 1, "R3 C after gaps");
        drive(PB, 0, "R7 B clears");
        // R8 malformed cycles
        drive(PA, 0, "R8 A");
        drive(PB, 0, "R8 B");
        drive(3'b101, 0, "R8 A+C dropped");
        drive(PC, 1, "R8 C still completes");
        drive(3'b110, 1, "R8 A+B dropped held");
        drive(3'b011, 1, "R8 B+C dropped held");
        drive(PB, 0, "R7 B clears");
        // R1 reset while held
        drive(PA, 0, "R1 A");
        drive(PB, 0, "R1 B");
        drive(PC, 1, "R1 C");
        do_reset("R1 reset from held");
        drive(PC, 0, "R1 idle after reset");
        drive(NONE, 0, "R3 idle quiet");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R3: %0d items left, expected 0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog R1: run hung, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule